// File: doc/BRIEF.md
# Logic BIST Session Engine

This block runs one built-in self-test session against a combinational circuit under test. A shift-register pattern source with XOR feedback drives stimulus onto the `pattern` port. A signature register folds the circuit's reply on the `response` port into a running checksum, one capture per clock. A small controller sequences the session and delivers a verdict.

A one-cycle `start` pulse latches the configuration inputs: feedback taps, seed, session length and expected signature. The same pulse loads the seed and clears the checksum. The engine then captures exactly the programmed number of responses and compares the checksum with the expected value. It raises `done` together with exactly one of `pass` or `fail`. The verdict holds until the next accepted `start`. A `start` that arrives while a session is running is ignored. Polynomial taps and the seed come from inputs so that one engine can cover several circuits. The checksum polynomial is fixed by a parameter.

Top module: `lbist_engine`

## Requirements
- R1: A `start` pulse sampled while the engine is idle or finished latches `cfg_taps`, `cfg_len` and `cfg_golden`, loads `cfg_seed` into the pattern register and clears the signature. In the cycle after that edge, `pattern` equals the seed.
- R2: When the sampled seed is all zeros, the pattern register is loaded with the value 1 instead, so the pattern is never zero during a session.
- R3: On each capture the pattern register shifts toward its MSB, and the new bit 0 is the XOR of the pattern bits selected by the latched taps (bit i of `cfg_taps` selects pattern bit i). With taps 8'hB8 and an 8-bit pattern, 255 distinct non-zero patterns appear in 255 steps.
- R4: On each capture, signature bit 0 becomes `response[0]` XOR the signature MSB. Each bit i above 0 becomes previous bit i-1 XOR `response[i]`, further XORed with the signature MSB where bit i of `MISR_POLY` is set.
- R5: A session captures exactly `cfg_len` responses, taken from the patterns seed, step 1, …, step L-1. `busy` is high for L+2 cycles after the start edge, and `done` rises one cycle later. A length of 0 captures nothing.
- R6: At the end of a session, `pass` is set if the signature equals the latched `cfg_golden`; otherwise `fail` is set. The two are never set together.
- R7: `done`, `pass` and `fail` hold their values until the next accepted `start`. A `start` pulse while `busy` is high has no effect on the session or its verdict.
- R8: After reset, `busy`, `done`, `pass` and `fail` are low and `pattern` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Session start pulse |
| cfg_taps | input | PAT_W | Pattern feedback tap mask |
| cfg_seed | input | PAT_W | Pattern seed |
| cfg_len | input | CNT_W | Number of captures in the session |
| cfg_golden | input | RSP_W | Expected final signature |
| response | input | RSP_W | Output of the circuit under test |
| pattern | output | PAT_W | Stimulus to the circuit under test |
| busy | output | 1 | Session running or being judged |
| done | output | 1 | Session finished, verdict valid |
| pass | output | 1 | Signature matched |
| fail | output | 1 | Signature mismatched |

## Verification
The bench builds the engine with an 8-bit pattern, an 8-bit signature, a 10-bit length counter and the checksum polynomial 8'h1D. With these values a 255-step maximal-length run fits in a short session, so every non-zero pattern can be observed directly. The bench also runs sessions of length zero, zero seeds, two different tap masks, a single flipped response bit, and a start pulse in the middle of a session. The 10-bit counter lets a full pattern period and the empty session both be exercised with the same build.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_CHECK = 2'd2,
      ST_DONE  = 2'd3
   } lbist_state_e;
endpackage

// File: rtl/lbist_lfsr.sv
module lbist_lfsr #(
   parameter int W          = 8,
   parameter bit SEED_GUARD = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] seed,
   input  logic [W-1:0] taps,
   input  logic         advance,
   output logic [W-1:0] state
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] state_q;
   logic [W-1:0] seed_eff;
   logic         fb;

   generate
      if (SEED_GUARD) begin : g_guard
         assign seed_eff = (seed == '0) ? ONE : seed;
      end else begin : g_raw
         assign seed_eff = seed;
      end
   endgenerate

   assign fb = ^(state_q & taps);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       state_q <= ONE;
      else if (load)    state_q <= seed_eff;
      else if (advance) state_q <= {state_q[W-2:0], fb};
   end

   assign state = state_q;

   generate
      if (SEED_GUARD) begin : g_nz_chk
         assert_state_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
            state_q != '0);
      end
   endgenerate

   assert_shift_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load) |=> state_q[W-1:1] == $past(state_q[W-2:0]));

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !load) |=> $stable(state_q));
endmodule

// File: rtl/lbist_misr.sv
module lbist_misr #(
   parameter int           W    = 8,
   parameter logic [W-1:0] POLY = 8'h1D
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         capture,
   input  logic [W-1:0] resp,
   output logic [W-1:0] sig
);
   logic [W-1:0] sig_q;
   logic [W-1:0] nxt;

   generate
      for (genvar i = 0; i < W; i++) begin : g_stage
         if (i == 0) begin : g_head
            assign nxt[i] = sig_q[W-1] ^ resp[i];
         end else if (POLY[i]) begin : g_tap
            assign nxt[i] = sig_q[i-1] ^ resp[i] ^ sig_q[W-1];
         end else begin : g_plain
            assign nxt[i] = sig_q[i-1] ^ resp[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sig_q <= '0;
      else if (clear)   sig_q <= '0;
      else if (capture) sig_q <= nxt;
   end

   assign sig = sig_q;

   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> sig_q == '0);

   assert_idle_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !capture) |=> $stable(sig_q));
endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
   import lbist_pkg::*;
#(
   parameter int PW = 8,
   parameter int RW = 8,
   parameter int CW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [PW-1:0] cfg_taps,
   input  logic [CW-1:0] cfg_len,
   input  logic [RW-1:0] cfg_golden,
   input  logic [RW-1:0] signature,
   output logic [PW-1:0] taps_q,
   output logic          load,
   output logic          step,
   output logic          busy,
   output logic          done,
   output logic          pass,
   output logic          fail
);
   lbist_state_e  state_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] len_q;
   logic [RW-1:0] gold_q;
   logic          done_q, pass_q, fail_q;

   assign load = start && (state_q == ST_IDLE || state_q == ST_DONE);
   assign step = (state_q == ST_RUN) && (cnt_q != len_q);
   assign busy = (state_q == ST_RUN) || (state_q == ST_CHECK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         len_q   <= '0;
         gold_q  <= '0;
         taps_q  <= '0;
         done_q  <= 1'b0;
         pass_q  <= 1'b0;
         fail_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE, ST_DONE: begin
               if (start) begin
                  state_q <= ST_RUN;
                  cnt_q   <= '0;
                  len_q   <= cfg_len;
                  gold_q  <= cfg_golden;
                  taps_q  <= cfg_taps;
                  done_q  <= 1'b0;
                  pass_q  <= 1'b0;
                  fail_q  <= 1'b0;
               end
            end
            ST_RUN: begin
               if (cnt_q == len_q) state_q <= ST_CHECK;
               else                cnt_q   <= cnt_q + CW'(1);
            end
            ST_CHECK: begin
               pass_q  <= (signature == gold_q);
               fail_q  <= (signature != gold_q);
               done_q  <= 1'b1;
               state_q <= ST_DONE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign done = done_q;
   assign pass = pass_q;
   assign fail = fail_q;

   assert_verdict_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pass ^ fail));

   assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable({pass, fail})));

   assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN) |-> (cnt_q <= len_q));

   assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(len_q) && $stable(gold_q) && $stable(taps_q)));
endmodule

// File: rtl/lbist_engine.sv
module lbist_engine #(
   parameter int               PAT_W      = 8,
   parameter int               RSP_W      = 8,
   parameter int               CNT_W      = 10,
   parameter logic [RSP_W-1:0] MISR_POLY  = 8'h1D,
   parameter bit               SEED_GUARD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [PAT_W-1:0] cfg_taps,
   input  logic [PAT_W-1:0] cfg_seed,
   input  logic [CNT_W-1:0] cfg_len,
   input  logic [RSP_W-1:0] cfg_golden,
   input  logic [RSP_W-1:0] response,
   output logic [PAT_W-1:0] pattern,
   output logic             busy,
   output logic             done,
   output logic             pass,
   output logic             fail
);
   generate
      if (PAT_W < 2) begin : g_bad_pat
         $error("lbist_engine: PAT_W must be at least 2");
      end
      if (RSP_W < 2) begin : g_bad_rsp
         $error("lbist_engine: RSP_W must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("lbist_engine: CNT_W must be at least 1");
      end
   endgenerate

   logic [PAT_W-1:0] taps_q;
   logic [RSP_W-1:0] signature;
   logic             load, step;

   lbist_ctrl #(.PW(PAT_W), .RW(RSP_W), .CW(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_taps(cfg_taps), .cfg_len(cfg_len), .cfg_golden(cfg_golden),
      .signature(signature), .taps_q(taps_q), .load(load), .step(step),
      .busy(busy), .done(done), .pass(pass), .fail(fail)
   );

   lbist_lfsr #(.W(PAT_W), .SEED_GUARD(SEED_GUARD)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .load(load), .seed(cfg_seed),
      .taps(taps_q), .advance(step), .state(pattern)
   );

   lbist_misr #(.W(RSP_W), .POLY(MISR_POLY)) u_misr (
      .clk(clk), .rst_n(rst_n), .clear(load), .capture(step),
      .resp(response), .sig(signature)
   );

   assert_start_seed_R1: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cfg_seed == '0 || pattern == $past(cfg_seed)));
endmodule

// File: tb/test_lbist_engine.sv
`timescale 1ns/1ps
module test_lbist_engine;
   localparam int PW = 8, RW = 8, CW = 10;
   localparam logic [7:0] MP = 8'h1D;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          start = 1'b0;
   logic [PW-1:0] cfg_taps = '0, cfg_seed = '0;
   logic [CW-1:0] cfg_len = '0;
   logic [RW-1:0] cfg_golden = '0;
   logic [RW-1:0] flip = '0;
   logic [RW-1:0] response;
   logic [PW-1:0] pattern;
   logic          busy, done, pass, fail;

   int vectors = 0;
   int miscompares = 0;

   function automatic logic [7:0] cut_f(input logic [7:0] p);
      return {p[6:0], p[7]} ^ (p & {p[0], p[7:1]}) ^ 8'h3C;
   endfunction

   function automatic logic [7:0] lfsr_f(input logic [7:0] s, input logic [7:0] t);
      return {s[6:0], ^(s & t)};
   endfunction

   function automatic logic [7:0] misr_f(input logic [7:0] s, input logic [7:0] r);
      logic [7:0] n;
      n = {s[6:0], 1'b0} ^ r;
      if (s[7]) n = n ^ (MP | 8'h01);
      return n;
   endfunction

   function automatic logic [7:0] sig_of(input logic [7:0] seed, input logic [7:0] taps,
                                         input int len, input int fk, input logic [7:0] fm);
      logic [7:0] l, s;
      l = (seed == 0) ? 8'h01 : seed;
      s = 8'h00;
      for (int k = 0; k < len; k++) begin
         s = misr_f(s, cut_f(l) ^ ((k == fk) ? fm : 8'h00));
         l = lfsr_f(l, taps);
      end
      return s;
   endfunction

   assign response = cut_f(pattern) ^ flip;

   lbist_engine #(.PAT_W(PW), .RSP_W(RW), .CNT_W(CW), .MISR_POLY(MP)) i_lbist_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_taps(cfg_taps),
      .cfg_seed(cfg_seed), .cfg_len(cfg_len), .cfg_golden(cfg_golden),
      .response(response), .pattern(pattern), .busy(busy), .done(done),
      .pass(pass), .fail(fail)
   );

   // behavioural reference: phase 0 idle, 1 run, 2 judge, 3 finished
   int         m_phase = 0;
   int         m_cnt = 0, m_len = 0;
   logic [7:0] m_lfsr = 8'h01, m_sig = 8'h00, m_taps = 8'h00, m_gold = 8'h00;
   logic       m_done = 0, m_pass = 0, m_fail = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_phase <= 0; m_lfsr <= 8'h01; m_sig <= 8'h00;
         m_done <= 0; m_pass <= 0; m_fail <= 0; m_cnt <= 0;
      end else if (m_phase == 0 || m_phase == 3) begin
         if (start) begin
            m_phase <= 1; m_cnt <= 0; m_len <= int'(cfg_len);
            m_taps <= cfg_taps; m_gold <= cfg_golden;
            m_lfsr <= (cfg_seed == 0) ? 8'h01 : cfg_seed;
            m_sig <= 8'h00; m_done <= 0; m_pass <= 0; m_fail <= 0;
         end
      end else if (m_phase == 1) begin
         if (m_cnt == m_len) m_phase <= 2;
         else begin
            m_sig  <= misr_f(m_sig, response);
            m_lfsr <= lfsr_f(m_lfsr, m_taps);
            m_cnt  <= m_cnt + 1;
         end
      end else begin
         m_pass <= (m_sig == m_gold);
         m_fail <= (m_sig != m_gold);
         m_done <= 1; m_phase <= 3;
      end
   end

   task automatic check1(input string req, input string what, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // per-clock comparison against the reference
   task automatic tick();
      @(negedge clk);
      vectors++;
      if (pattern !== m_lfsr || busy !== (m_phase == 1 || m_phase == 2) ||
          done !== m_done || pass !== m_pass || fail !== m_fail) begin
         miscompares++;
         $display("FAIL R3/R5/R6/R7 clock compare: actual pat=%0h busy=%0b done=%0b pass=%0b fail=%0b expected pat=%0h busy=%0b done=%0b pass=%0b fail=%0b",
                  pattern, busy, done, pass, fail, m_lfsr,
                  (m_phase == 1 || m_phase == 2), m_done, m_pass, m_fail);
      end
   endtask

   bit seen[256];
   bit rec = 0;
   int first_pat;

   // returns number of ticks from the start tick until done seen
   task automatic session(input logic [7:0] seed, input logic [7:0] taps, input int len,
                          input logic [7:0] gold, input int fk, input logic [7:0] fm,
                          input int mid_start, output int ticks);
      cfg_seed = seed; cfg_taps = taps; cfg_len = CW'(len); cfg_golden = gold;
      start = 1'b1;
      tick();
      start = 1'b0;
      first_pat = int'(pattern);
      ticks = 1;
      while (!done && ticks < 2000) begin
         if (rec && busy) seen[pattern] = 1'b1;
         flip = (m_phase == 1 && m_cnt == fk) ? fm : 8'h00;
         if (ticks == mid_start) begin
            start = 1'b1; cfg_seed = 8'h77; cfg_taps = 8'h8E;
            cfg_len = CW'(3); cfg_golden = ~gold;
         end else start = 1'b0;
         tick();
         ticks++;
      end
      flip = 8'h00; start = 1'b0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL R5 watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      int t, cnt;
      logic [7:0] g;
      repeat (3) @(negedge clk);
      // R8: reset values
      check1("R8", "pattern at reset", int'(pattern), 1);
      check1("R8", "busy/done/pass/fail at reset", int'({busy, done, pass, fail}), 0);
      rst_n = 1'b1;
      tick(); tick();

      // R1 R4 R6: matching signature passes
      g = sig_of(8'h5A, 8'hB8, 40, -1, 8'h00);
      session(8'h5A, 8'hB8, 40, g, -1, 8'h00, -1, t);
      check1("R1", "first pattern equals seed", first_pat, 8'h5A);
      check1("R4", "pass with model signature", int'(pass), 1);
      check1("R5", "ticks to done for L=40", t, 43);

      // R6: one flipped response bit fails
      session(8'h5A, 8'hB8, 40, g, 17, 8'h04, -1, t);
      check1("R6", "fail after flipped bit", int'({pass, fail}), 1);

      // R2: zero seed behaves as seed 1
      g = sig_of(8'h00, 8'hB8, 10, -1, 8'h00);
      session(8'h00, 8'hB8, 10, g, -1, 8'h00, -1, t);
      check1("R2", "first pattern for zero seed", first_pat, 1);
      check1("R2", "pass for zero seed", int'(pass), 1);

      // R3: maximal length run
      for (int i = 0; i < 256; i++) seen[i] = 1'b0;
      rec = 1;
      g = sig_of(8'h01, 8'hB8, 255, -1, 8'h00);
      session(8'h01, 8'hB8, 255, g, -1, 8'h00, -1, t);
      rec = 0;
      cnt = 0;
      for (int i = 1; i < 256; i++) if (seen[i]) cnt++;
      check1("R3", "distinct non-zero patterns", cnt, 255);
      check1("R3", "zero pattern seen", int'(seen[0]), 0);
      check1("R6", "pass for full period", int'(pass), 1);

      // R3: other taps and seed
      g = sig_of(8'hC3, 8'h8E, 60, -1, 8'h00);
      session(8'hC3, 8'h8E, 60, g, -1, 8'h00, -1, t);
      check1("R3", "pass with taps 8E", int'(pass), 1);

      // R5: empty session
      session(8'h3A, 8'hB8, 0, 8'h00, -1, 8'h00, -1, t);
      check1("R5", "ticks to done for L=0", t, 3);
      check1("R5", "pass for empty session", int'({pass, fail}), 2);

      // R7: start while busy is ignored, verdict holds
      g = sig_of(8'h91, 8'hB8, 30, -1, 8'h00);
      session(8'h91, 8'hB8, 30, g, -1, 8'h00, 10, t);
      check1("R7", "ticks unchanged by mid start", t, 33);
      check1("R7", "pass unchanged by mid start", int'({pass, fail}), 2);
      for (int i = 0; i < 5; i++) tick();
      check1("R7", "verdict held", int'({done, pass, fail}), 6);

      finish_run();
   end
endmodule